// File: doc/BRIEF.md
# Priority-Interleaved I/O Sequence Selector

This block chooses which instruction stream the processor executes next when several I/O units want service. Every unit owns its own instruction stream and a ready flag, which it raises when it needs attention. At each instruction boundary the selector picks the lowest-numbered flagged unit. If no unit is flagged, it falls back to the background computation stream. If that stream has no work either, the selector enters an idle wait.

Each stream has a private resume-address register. On a switch, the program counter of the stream being left is stored in that stream's register, and the resume address of the incoming stream is presented on `nextPc` in the same cycle. The running unit can retire its request with a dismiss pulse. The selector turns that pulse into a clear pulse aimed at the running unit's flag. It also stops counting that unit as a candidate from the same cycle onward.

Top module: `stream_sel`

## Requirements
- R1: A switch decision chooses the flagged unit with the lowest index. Unit 0 has the highest priority. `curStream` shows the chosen unit's index from the next clock edge.
- R2: The background stream has index NUM_UNITS (21 by default). It is chosen at a decision when no unit is eligible and `mainWork` is 1.
- R3: A decision with no eligible unit and `mainWork` = 0 sets `idle` to 1 and leaves `curStream` at the last running stream. While idle, a decision is made every cycle without waiting for `switchOk`.
- R4: A decision is made when `switchOk` = 1 or the selector is idle. If the decision picks a stream other than the running one, `curPc` is stored in the leaving stream's resume register. In the same cycle, `nextPc` shows the chosen stream's stored resume address. No store happens when leaving idle.
- R5: With `switchOk` = 0 and not idle, `curStream` and `idle` hold and `nextPc` equals `curPc`.
- R6: If the decision picks the stream that is already running, `nextPc` equals `curPc` and no resume register is written.
- R7: The running unit k can dismiss in a cycle. That cycle, `flagClear` has only bit k set, and unit k is not eligible at that cycle's decision. A dismiss while the background stream runs or while idle gives `flagClear` = 0.
- R8: After reset, `curStream` is NUM_UNITS, `idle` is 0 and every resume register holds 0.
- R9: The default configuration serves 21 units with 16-bit program counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| unitFlag | input | NUM_UNITS | Ready flags, bit i for unit i |
| mainWork | input | 1 | Background stream has work |
| switchOk | input | 1 | Instruction boundary: a switch is allowed |
| dismiss | input | 1 | Running unit retires its request |
| curPc | input | PC_W | Program counter of the running stream |
| curStream | output | SEL_W | Index of the running (or last running) stream |
| nextPc | output | PC_W | Program counter to execute next |
| idle | output | 1 | Idle wait, no stream running |
| flagClear | output | NUM_UNITS | One-cycle clear pulse to a unit's flag |

## Verification
The assertions assume that `curPc` is stable and meaningful in any cycle where `switchOk` or idle causes a decision. They also assume that a device keeps its flag raised until the clear pulse reaches it. The stimulus changes inputs only on the falling clock edge. It drops a unit's flag only after that unit was dismissed, or while a different stream is chosen. The stimulus also revisits streams so that stored resume addresses are read back through `nextPc`. This is how the save/no-save rules are observed without looking inside the block.

// File: rtl/stream_sel_pkg.sv
package stream_sel_pkg;
  // strobes from sequencing control to the resume-address datapath
  typedef struct packed {
    logic saveEn;   // store curPc into the leaving stream's register
    logic loadEn;   // present the chosen stream's register on nextPc
  } seqStrobes_t;
endpackage

// File: rtl/stream_sel_prio.sv
module stream_sel_prio #(
  parameter int NUM_UNITS = 21,
  parameter int SEL_W     = $clog2(NUM_UNITS + 1)
) (
  input  logic [NUM_UNITS-1:0] eligible,
  input  logic                 mainWork,
  output logic [SEL_W-1:0]     winner,
  output logic                 winnerValid
);
  localparam logic [SEL_W-1:0] MAIN_ID = SEL_W'(NUM_UNITS);

  always_comb begin
    winner      = MAIN_ID;
    winnerValid = mainWork;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winner      = SEL_W'(i);
        winnerValid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/stream_sel_ctrl.sv
module stream_sel_ctrl
  import stream_sel_pkg::*;
#(
  parameter int NUM_UNITS = 21,
  parameter int SEL_W     = $clog2(NUM_UNITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_UNITS-1:0] unitFlag,
  input  logic                 mainWork,
  input  logic                 switchOk,
  input  logic                 dismiss,
  output seqStrobes_t          strobes,
  output logic [SEL_W-1:0]     saveIdx,
  output logic [SEL_W-1:0]     loadIdx,
  output logic [SEL_W-1:0]     runStream,
  output logic                 idleQ,
  output logic [NUM_UNITS-1:0] clearMask
);
  localparam logic [SEL_W-1:0] MAIN_ID = SEL_W'(NUM_UNITS);

  logic [NUM_UNITS-1:0] eligible;
  logic [SEL_W-1:0]     winner;
  logic                 winnerValid;
  logic                 decide;
  logic                 differs;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_clr
    assign clearMask[g] = dismiss && !idleQ && (runStream == SEL_W'(g));
  end

  assign eligible = unitFlag & ~clearMask;

  stream_sel_prio #(.NUM_UNITS(NUM_UNITS), .SEL_W(SEL_W)) u_prio (
    .eligible   (eligible),
    .mainWork   (mainWork),
    .winner     (winner),
    .winnerValid(winnerValid)
  );

  assign decide  = switchOk || idleQ;
  assign differs = winner != runStream;

  always_comb begin
    strobes.saveEn = decide && !idleQ && (!winnerValid || differs);
    strobes.loadEn = decide && winnerValid && (idleQ || differs);
  end

  assign saveIdx = runStream;
  assign loadIdx = winner;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runStream <= MAIN_ID;
      idleQ     <= 1'b0;
    end else if (decide) begin
      idleQ <= !winnerValid;
      if (winnerValid) runStream <= winner;
    end
  end
endmodule

// File: rtl/stream_sel_dp.sv
module stream_sel_dp
  import stream_sel_pkg::*;
#(
  parameter int NUM_STREAMS = 22,
  parameter int PC_W        = 16,
  parameter int SEL_W       = $clog2(NUM_STREAMS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strobes,
  input  logic [SEL_W-1:0] saveIdx,
  input  logic [SEL_W-1:0] loadIdx,
  input  logic [PC_W-1:0]  curPc,
  output logic [PC_W-1:0]  nextPc
);
  logic [PC_W-1:0] savedPc [NUM_STREAMS];

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        savedPc[g] <= '0;
      else if (strobes.saveEn && saveIdx == SEL_W'(g))
        savedPc[g] <= curPc;
    end
  end

  assign nextPc = strobes.loadEn ? savedPc[loadIdx] : curPc;
endmodule

// File: rtl/stream_sel.sv
module stream_sel
  import stream_sel_pkg::*;
#(
  parameter int NUM_UNITS = 21,
  parameter int PC_W      = 16,
  localparam int NUM_STREAMS = NUM_UNITS + 1,
  localparam int SEL_W       = $clog2(NUM_STREAMS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_UNITS-1:0] unitFlag,
  input  logic                 mainWork,
  input  logic                 switchOk,
  input  logic                 dismiss,
  input  logic [PC_W-1:0]      curPc,
  output logic [SEL_W-1:0]     curStream,
  output logic [PC_W-1:0]      nextPc,
  output logic                 idle,
  output logic [NUM_UNITS-1:0] flagClear
);
  seqStrobes_t      strobes;
  logic [SEL_W-1:0] saveIdx;
  logic [SEL_W-1:0] loadIdx;

  stream_sel_ctrl #(.NUM_UNITS(NUM_UNITS), .SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .unitFlag (unitFlag),
    .mainWork (mainWork),
    .switchOk (switchOk),
    .dismiss  (dismiss),
    .strobes  (strobes),
    .saveIdx  (saveIdx),
    .loadIdx  (loadIdx),
    .runStream(curStream),
    .idleQ    (idle),
    .clearMask(flagClear)
  );

  stream_sel_dp #(.NUM_STREAMS(NUM_STREAMS), .PC_W(PC_W), .SEL_W(SEL_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .saveIdx(saveIdx),
    .loadIdx(loadIdx),
    .curPc  (curPc),
    .nextPc (nextPc)
  );
endmodule

// File: rtl/stream_sel_checker.sv
module stream_sel_checker #(
  parameter int NUM_UNITS = 21,
  parameter int PC_W      = 16,
  parameter int SEL_W     = $clog2(NUM_UNITS + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_UNITS-1:0] unitFlag,
  input logic                 mainWork,
  input logic                 switchOk,
  input logic                 dismiss,
  input logic [PC_W-1:0]      curPc,
  input logic [SEL_W-1:0]     curStream,
  input logic [PC_W-1:0]      nextPc,
  input logic                 idle,
  input logic [NUM_UNITS-1:0] flagClear
);
  localparam logic [SEL_W-1:0] MAIN_ID = SEL_W'(NUM_UNITS);

  assert_top_prio_R1: assert property (@(posedge clk) disable iff (!rstN)
    (switchOk && !idle && unitFlag[0] && !(dismiss && curStream == '0))
      |=> (curStream == '0 && !idle));

  assert_main_fallback_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((switchOk || idle) && unitFlag == '0 && mainWork)
      |=> (curStream == MAIN_ID && !idle));

  assert_go_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((switchOk || idle) && unitFlag == '0 && !mainWork) |=> idle);

  assert_hold_stream_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!switchOk && !idle) |=> ($stable(curStream) && !idle));

  assert_hold_pc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!switchOk && !idle) |-> (nextPc == curPc));

  assert_one_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flagClear));

  assert_clear_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear != '0) |-> (dismiss && !idle && curStream != MAIN_ID));
endmodule

bind stream_sel stream_sel_checker #(.NUM_UNITS(NUM_UNITS), .PC_W(PC_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .unitFlag (unitFlag),
  .mainWork (mainWork),
  .switchOk (switchOk),
  .dismiss  (dismiss),
  .curPc    (curPc),
  .curStream(curStream),
  .nextPc   (nextPc),
  .idle     (idle),
  .flagClear(flagClear)
);

// File: tb/stream_sel_bench.sv
`timescale 1ns/1ps
module stream_sel_bench;
  localparam int NU = 21;
  localparam int PW = 16;
  localparam int SW = 5;
  localparam int NV = 16;

  typedef struct packed {
    logic [NU-1:0] flags;
    logic          mainW;
    logic          ok;
    logic          dis;
    logic [PW-1:0] pc;
    logic [PW-1:0] expPc;
    logic [NU-1:0] expClr;
    logic [SW-1:0] expStr;
    logic          expIdle;
  } vec_t;

  // bit k of flags/expClr is unit k; stream 21 is the background stream
  localparam vec_t VECS [NV] = '{
    '{21'h000000, 1'b1, 1'b1, 1'b0, 16'h0100, 16'h0100, 21'h000000, 5'd21, 1'b0}, // R6 main stays
    '{21'h000020, 1'b1, 1'b0, 1'b0, 16'h0101, 16'h0101, 21'h000000, 5'd21, 1'b0}, // R5 no strobe
    '{21'h000020, 1'b1, 1'b1, 1'b0, 16'h0102, 16'h0000, 21'h000000, 5'd5,  1'b0}, // R1 R4
    '{21'h000028, 1'b1, 1'b1, 1'b0, 16'h0500, 16'h0000, 21'h000000, 5'd3,  1'b0}, // R1 lower wins
    '{21'h000028, 1'b1, 1'b1, 1'b1, 16'h0300, 16'h0500, 21'h000008, 5'd5,  1'b0}, // R7 R4
    '{21'h000020, 1'b1, 1'b1, 1'b1, 16'h0501, 16'h0102, 21'h000020, 5'd21, 1'b0}, // R7 R2
    '{21'h100001, 1'b1, 1'b1, 1'b0, 16'h0103, 16'h0000, 21'h000000, 5'd0,  1'b0}, // R1
    '{21'h100001, 1'b1, 1'b1, 1'b0, 16'h0010, 16'h0010, 21'h000000, 5'd0,  1'b0}, // R6 same
    '{21'h100000, 1'b1, 1'b1, 1'b1, 16'h0011, 16'h0000, 21'h000001, 5'd20, 1'b0}, // R7 R1
    '{21'h000000, 1'b0, 1'b1, 1'b1, 16'h2000, 16'h2000, 21'h100000, 5'd20, 1'b1}, // R3 enter idle
    '{21'h000000, 1'b0, 1'b0, 1'b1, 16'h7777, 16'h7777, 21'h000000, 5'd20, 1'b1}, // R3 R7 idle
    '{21'h100000, 1'b0, 1'b0, 1'b0, 16'h7778, 16'h2000, 21'h000000, 5'd20, 1'b0}, // R3 R4 wake
    '{21'h000000, 1'b1, 1'b1, 1'b0, 16'h2001, 16'h0103, 21'h000000, 5'd21, 1'b0}, // R2 R4
    '{21'h000001, 1'b1, 1'b1, 1'b0, 16'h0104, 16'h0011, 21'h000000, 5'd0,  1'b0}, // R6 R4
    '{21'h000000, 1'b1, 1'b1, 1'b0, 16'h0012, 16'h0104, 21'h000000, 5'd21, 1'b0}, // R2
    '{21'h000001, 1'b1, 1'b1, 1'b1, 16'h0105, 16'h0012, 21'h000000, 5'd0,  1'b0}  // R7 main dismiss
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic [NU-1:0] unitFlag;
  logic          mainWork;
  logic          switchOk;
  logic          dismiss;
  logic [PW-1:0] curPc;
  logic [SW-1:0] curStream;
  logic [PW-1:0] nextPc;
  logic          idle;
  logic [NU-1:0] flagClear;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  stream_sel u_stream_sel (
    .clk(clk), .rstN(rstN), .unitFlag(unitFlag), .mainWork(mainWork),
    .switchOk(switchOk), .dismiss(dismiss), .curPc(curPc),
    .curStream(curStream), .nextPc(nextPc), .idle(idle), .flagClear(flagClear)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    unitFlag = v.flags;
    mainWork = v.mainW;
    switchOk = v.ok;
    dismiss  = v.dis;
    curPc    = v.pc;
  endtask

  initial begin
    rstN = 1'b0;
    unitFlag = '0; mainWork = 1'b1; switchOk = 1'b0; dismiss = 1'b0; curPc = 16'h0042;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R8 stream", 32'(curStream), 32'd21);
    chk("R8 idle", 32'(idle), 32'd0);
    chk("R5 nextPc", 32'(nextPc), 32'h0042);
    chk("R7 clear", 32'(flagClear), 32'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      #1;
      chk($sformatf("R4 nextPc step %0d", i), 32'(nextPc), 32'(VECS[i].expPc));
      chk($sformatf("R7 flagClear step %0d", i), 32'(flagClear), 32'(VECS[i].expClr));
      @(negedge clk);
      chk($sformatf("R1 curStream step %0d", i), 32'(curStream), 32'(VECS[i].expStr));
      chk($sformatf("R3 idle step %0d", i), 32'(idle), 32'(VECS[i].expIdle));
    end

    // R8: reset clears every resume register (unit 3 held 16'h0300)
    switchOk = 1'b0; dismiss = 1'b0; unitFlag = '0;
    rstN = 1'b0;
    @(negedge clk);
    chk("R8 stream after reset", 32'(curStream), 32'd21);
    rstN = 1'b1;
    unitFlag = 21'h000008; switchOk = 1'b1; curPc = 16'h0900;
    #1;
    chk("R8 cleared resume value", 32'(nextPc), 32'h0000);
    @(negedge clk);
    chk("R1 stream 3", 32'(curStream), 32'd3);
    // R2: returning to background shows stored 16'h0900
    unitFlag = '0; curPc = 16'h0333;
    #1;
    chk("R2 R4 back to main", 32'(nextPc), 32'h0900);
    @(negedge clk);
    chk("R2 stream", 32'(curStream), 32'd21);
    // R9: highest unit index 20 selectable
    unitFlag = 21'h100000; curPc = 16'h0901;
    @(negedge clk);
    chk("R9 unit 20", 32'(curStream), 32'd20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule